// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a synthesizable slave memory on a two-wire serial bus. It holds a 2048-byte array. It watches the bus clock and data lines through a system-clock synchroniser and recognises start and stop conditions. It acknowledges its device code and carries out byte writes, page writes, and three kinds of read: from the current address, from a random address, and sequential. The data line is driven only as an open-drain pull-low enable.

A write transaction collects up to one page of bytes in a 16-entry buffer. When the closing stop condition arrives, the buffer is committed during a self-timed write cycle. The cycle lasts a parameterised number of clocks and is reported on `busy`. While the cycle runs, the slave ignores its own address, so a master can poll for completion. A level on `wp` makes the upper half of the array read-only. The word-address counter keeps its value between transactions.

Top module: `eeprom_slave2w`

## Requirements
- R1: After reset `sda_oe` is 0 and `busy` is 0. A falling data line while the bus clock is high is a start condition, and a rising data line while the bus clock is high is a stop condition.
- R2: The first byte after a start is the device byte. Bits 7..4 must equal 4'b1010 to be acknowledged. If any other code arrives, the data line stays released through the ninth clock.
- R3: In a write, device-byte bits 3..1 give word-address bits 10..8 and bit 0 = 0 selects write. The next byte gives address bits 7..0, and each following data byte is stored at the counter's address.
- R4: A page write accepts any number of data bytes. Only address bits 3..0 advance, so a 16-byte page wraps onto itself, and a later byte to the same location replaces an earlier one.
- R5: The write cycle starts at a stop that follows at least one data byte, and `busy` is then high for exactly WRITE_CYCLES clocks. A stop with no data bytes starts no cycle. A repeated start discards data bytes not yet committed.
- R6: While `busy` is high, a valid device byte is not acknowledged.
- R7: The level of `wp` at the stop is used for the write cycle. When that level is 1, addresses 0x400..0x7FF keep their contents and the lower half is still written. Data bytes are acknowledged either way.
- R8: A read with device-byte bit 0 = 1 and no preceding address phase starts at the retained counter. That counter is one past the last byte read, or the next in-page position after a write. The read ignores device-byte bits 3..1.
- R9: A random read is a write device byte and a word-address byte, then a repeated start and a read device byte. It returns data from the given address.
- R10: In a read, each byte goes out MSB first, and the counter advances over all 11 bits, wrapping 0x7FF to 0x000. A master acknowledge (0) in the ninth clock asks for another byte. A non-acknowledge (1) ends the read, and the line is released.
- R11: The slave asserts its acknowledge, and changes its read data, only while the bus clock is low. `sda_oe` never changes during a high phase of the bus clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| wp | input | 1 | 1 locks addresses 0x400..0x7FF against writes |
| sda_oe | output | 1 | 1 pulls the data line low |
| busy | output | 1 | High while the self-timed write cycle runs |

## Verification
A wrong state in the control sequencer shows up on the data line within one bus bit-time. It appears as a missing or misplaced acknowledge, or as read bits that start on the wrong clock, and in the worst case as `sda_oe` changing during a clock-high phase. A wrong word-address counter or page buffer shows nothing until a later read. Because of that, every write is read back through both current-address and random reads, and the reads also cover the page wrap and the 0x7FF-to-0x000 wrap. Write-protect and discard errors appear as stale or altered bytes on those reads. A wrong busy counter shows directly as a `busy` pulse of the wrong length, or as an acknowledge given during a poll.

// File: rtl/ee_pkg.sv
package ee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_WADR, ST_WDAT, ST_ACK, ST_RDAT, ST_RACK
  } eeState_t;

  // strobes from sequencer to datapath, one clock wide
  typedef struct packed {
    logic shiftIn;   // capture one bit on rising bus clock
    logic ldHi;      // latch high address bits from device byte
    logic ldWord;    // load full word address
    logic bufWr;     // store completed data byte into page buffer
    logic ldRead;    // load array byte into transmit register, advance counter
    logic shiftOut;  // present next transmit bit
    logic clrBuf;    // start condition: drop uncommitted page data
    logic stopSeen;  // stop condition
  } eeStrobe_t;
endpackage

// File: rtl/ee_ctrl.sv
module ee_ctrl
  import ee_pkg::*;
#(
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic      busy,
  input  logic [7:0] rxByte,
  output eeStrobe_t str,
  output logic      rxBit,
  output logic      ackDrive,
  output logic      txDrive
);
  logic [2:0] sclPipe, sdaPipe;
  logic sclQ, sclD, sdaQ, sdaD;
  logic sclRise, sclFall, startC, stopC;

  eeState_t state, stateN, nextSt, nextStN;
  logic [2:0] bitCnt, bitCntN;
  logic phase, phaseN, ackGive, ackGiveN, ackDriveN, txDriveN;
  logic contRead, contReadN, ackIsDev, ackIsDevN;
  logic [7:0] inByte;
  logic devMatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclPipe <= 3'b111;
      sdaPipe <= 3'b111;
    end else begin
      sclPipe <= {sclPipe[1:0], sclIn};
      sdaPipe <= {sdaPipe[1:0], sdaIn};
    end
  end

  assign sclQ = sclPipe[1];
  assign sclD = sclPipe[2];
  assign sdaQ = sdaPipe[1];
  assign sdaD = sdaPipe[2];
  assign sclRise = sclQ & ~sclD;
  assign sclFall = ~sclQ & sclD;
  assign startC  = sclQ & sclD & sdaD & ~sdaQ;
  assign stopC   = sclQ & sclD & ~sdaD & sdaQ;
  assign rxBit   = sdaQ;
  assign inByte  = {rxByte[6:0], sdaQ};
  assign devMatch = (inByte[7:4] == DEV_CODE) && !busy;

  always_comb begin
    stateN    = state;
    nextStN   = nextSt;
    bitCntN   = bitCnt;
    phaseN    = phase;
    ackGiveN  = ackGive;
    ackDriveN = ackDrive;
    txDriveN  = txDrive;
    contReadN = contRead;
    ackIsDevN = ackIsDev;
    str       = '0;
    if (startC) begin
      stateN     = ST_DEV;
      bitCntN    = '0;
      ackDriveN  = 1'b0;
      txDriveN   = 1'b0;
      str.clrBuf = 1'b1;
    end else if (stopC) begin
      stateN       = ST_IDLE;
      ackDriveN    = 1'b0;
      txDriveN     = 1'b0;
      str.stopSeen = 1'b1;
    end else begin
      unique case (state)
        ST_DEV, ST_WADR, ST_WDAT: begin
          if (sclRise) begin
            str.shiftIn = 1'b1;
            bitCntN     = 3'(bitCnt + 3'd1);
            if (bitCnt == 3'd7) begin
              stateN    = ST_ACK;
              phaseN    = 1'b0;
              ackIsDevN = (state == ST_DEV);
              if (state == ST_DEV) begin
                ackGiveN = devMatch;
                nextStN  = inByte[0] ? ST_RDAT : ST_WADR;
                str.ldHi = devMatch & ~inByte[0];
              end else if (state == ST_WADR) begin
                ackGiveN   = 1'b1;
                nextStN    = ST_WDAT;
                str.ldWord = 1'b1;
              end else begin
                ackGiveN  = 1'b1;
                nextStN   = ST_WDAT;
                str.bufWr = 1'b1;
              end
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            if (!phase) begin
              ackDriveN = ackGive;
              phaseN    = 1'b1;
            end else begin
              ackDriveN = 1'b0;
              bitCntN   = '0;
              stateN    = ackGive ? nextSt : ST_IDLE;
              if (ackGive && nextSt == ST_RDAT) begin
                str.ldRead = 1'b1;
                txDriveN   = 1'b1;
              end
            end
          end
        end
        ST_RDAT: begin
          if (sclFall) str.shiftOut = 1'b1;
          if (sclRise) begin
            bitCntN = 3'(bitCnt + 3'd1);
            if (bitCnt == 3'd7) begin
              stateN = ST_RACK;
              phaseN = 1'b0;
            end
          end
        end
        ST_RACK: begin
          if (sclFall) begin
            if (!phase) begin
              txDriveN = 1'b0;
            end else if (contRead) begin
              str.ldRead = 1'b1;
              txDriveN   = 1'b1;
              bitCntN    = '0;
              stateN     = ST_RDAT;
            end
          end
          if (sclRise) begin
            phaseN    = 1'b1;
            contReadN = ~sdaQ;
            if (sdaQ) stateN = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      nextSt   <= ST_IDLE;
      bitCnt   <= '0;
      phase    <= 1'b0;
      ackGive  <= 1'b0;
      ackDrive <= 1'b0;
      txDrive  <= 1'b0;
      contRead <= 1'b0;
      ackIsDev <= 1'b0;
    end else begin
      state    <= stateN;
      nextSt   <= nextStN;
      bitCnt   <= bitCntN;
      phase    <= phaseN;
      ackGive  <= ackGiveN;
      ackDrive <= ackDriveN;
      txDrive  <= txDriveN;
      contRead <= contReadN;
      ackIsDev <= ackIsDevN;
    end
  end

  // R11: acknowledge and read data only start while the bus clock is low
  p_ack_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ackDrive) |-> !$past(sclQ));
  p_tx_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txDrive) |-> !$past(sclQ));
  // R11: pull-low for acknowledge only inside the acknowledge slot
  p_ack_slot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ackDrive |-> state == ST_ACK);
  // R6: no device acknowledge while the write cycle runs
  p_busy_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ackDrive) && ackIsDev) |-> !$past(busy));
endmodule

// File: rtl/ee_dpath.sv
module ee_dpath
  import ee_pkg::*;
#(
  parameter int MEM_BYTES    = 2048,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 750000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  eeStrobe_t str,
  input  logic      rxBit,
  input  logic      wp,
  output logic [7:0] rxByte,
  output logic      txMsb,
  output logic      busy
);
  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int HI_W   = ADDR_W - 8;
  localparam int CNT_W  = $clog2(WRITE_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WRITE_CYCLES - 1);

  initial assert (WRITE_CYCLES >= PAGE_BYTES && HI_W >= 1);

  logic [7:0] rxSh, txSh, byteIn, memQ;
  logic [HI_W-1:0] devHi;
  logic [ADDR_W-1:0] addrCnt;
  logic [7:0] bufData [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] bufMask;
  logic [CNT_W-1:0] idx;
  logic [PAGE_W-1:0] idxLow;
  logic [ADDR_W-PAGE_W-1:0] pageL;
  logic wpL, memWe;
  logic [ADDR_W-1:0] memWaddr;
  logic [7:0] mem [MEM_BYTES];

  assign byteIn = {rxSh[6:0], rxBit};
  assign rxByte = rxSh;
  assign txMsb  = txSh[7];
  assign idxLow = idx[PAGE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxSh    <= '0;
      txSh    <= '0;
      devHi   <= '0;
      addrCnt <= '0;
    end else begin
      if (str.shiftIn)  rxSh <= byteIn;
      if (str.ldRead)   txSh <= memQ;
      else if (str.shiftOut) txSh <= {txSh[6:0], 1'b0};
      if (str.ldHi)     devHi <= byteIn[HI_W:1];
      if (str.ldWord)   addrCnt <= {devHi, byteIn};
      else if (str.bufWr)
        addrCnt[PAGE_W-1:0] <= PAGE_W'(addrCnt[PAGE_W-1:0] + 1'b1);
      else if (str.ldRead)
        addrCnt <= ADDR_W'(addrCnt + 1'b1);
    end
  end

  // page buffer: byte slots plus a mask of slots filled in this transaction
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_BYTES; i++) bufData[i] <= '0;
      bufMask <= '0;
    end else begin
      if (busy && idx == LAST) bufMask <= '0;
      else if (!busy && str.clrBuf) bufMask <= '0;
      else if (str.bufWr) begin
        bufMask[addrCnt[PAGE_W-1:0]] <= 1'b1;
        bufData[addrCnt[PAGE_W-1:0]] <= byteIn;
      end
    end
  end

  // self-timed write cycle; the first PAGE_BYTES clocks drain the buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      wpL   <= 1'b0;
      pageL <= '0;
    end else if (!busy) begin
      if (str.stopSeen && |bufMask) begin
        busy  <= 1'b1;
        idx   <= '0;
        wpL   <= wp;
        pageL <= addrCnt[ADDR_W-1:PAGE_W];
      end
    end else begin
      if (idx == LAST) busy <= 1'b0;
      else idx <= CNT_W'(idx + 1'b1);
    end
  end

  assign memWaddr = {pageL, idxLow};
  assign memWe = busy && ({1'b0, idx} < (CNT_W+1)'(PAGE_BYTES)) && bufMask[idxLow]
                 && !(wpL && pageL[ADDR_W-PAGE_W-1]);

  always_ff @(posedge clk) begin
    if (memWe) mem[memWaddr] <= bufData[idxLow];
    memQ <= mem[addrCnt];
  end

  // R7: protected half never written when the latched lock is set
  p_protect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (memWe && wpL) |-> !memWaddr[ADDR_W-1]);
  // R4: buffered bytes leave the page number unchanged
  p_page_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    str.bufWr |=> addrCnt[ADDR_W-1:PAGE_W] == $past(addrCnt[ADDR_W-1:PAGE_W]));
  // R10: each read byte advances the full counter by one
  p_read_inc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    str.ldRead |=> addrCnt == ADDR_W'($past(addrCnt) + 1'b1));
  // R5: write cycle ends only after its full count
  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(idx) == LAST);
endmodule

// File: rtl/eeprom_slave2w.sv
module eeprom_slave2w
  import ee_pkg::*;
#(
  parameter int MEM_BYTES    = 2048,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 750000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp,
  output logic sda_oe,
  output logic busy
);
  eeStrobe_t str;
  logic rxBit, ackDrive, txDrive, txMsb;
  logic [7:0] rxByte;

  ee_ctrl #(.DEV_CODE(4'b1010)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sclIn(scl_i), .sdaIn(sda_i), .busy(busy),
    .rxByte(rxByte), .str(str), .rxBit(rxBit), .ackDrive(ackDrive), .txDrive(txDrive)
  );

  ee_dpath #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)) u_dpath (
    .clk(clk), .rst_n(rst_n), .str(str), .rxBit(rxBit), .wp(wp),
    .rxByte(rxByte), .txMsb(txMsb), .busy(busy)
  );

  assign sda_oe = ackDrive | (txDrive & ~txMsb);
endmodule

// File: tb/sim_eeprom_slave2w.sv
module sim_eeprom_slave2w;
  localparam int WC = 300;
  localparam int H  = 10;

  logic clk = 1'b0, rst_n = 1'b0, mScl = 1'b1, mSda = 1'b1, wpLvl = 1'b0;
  logic sda_oe, busy;
  wire  sdaLine = mSda & ~sda_oe;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  int model [2048];
  int modelAddr = 0;

  always #4 clk = ~clk;

  eeprom_slave2w #(.WRITE_CYCLES(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(mScl), .sda_i(sdaLine), .wp(wpLvl),
    .sda_oe(sda_oe), .busy(busy)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R11 monitor: sda_oe must hold during every clock-high phase
  logic prevScl = 1'b1, prevOe = 1'b0;
  int r11Bad = 0;
  always @(negedge clk) begin
    if (rst_n && mScl && prevScl && sda_oe != prevOe) r11Bad++;
    prevScl <= mScl;
    prevOe  <= sda_oe;
  end

  task automatic startBus();
    mSda = 1'b1; tick(H/2);
    mScl = 1'b1; tick(H);
    mSda = 1'b0; tick(H);
    mScl = 1'b0; tick(H/2);
  endtask

  task automatic stopBus();
    mSda = 1'b0; tick(H/2);
    mScl = 1'b1; tick(H);
    mSda = 1'b1;
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = v[i]; tick(H/2);
      mScl = 1'b1; tick(H);
      mScl = 1'b0; tick(H/2);
    end
    mSda = 1'b1; tick(H/2);
    mScl = 1'b1; tick(H/2);
    ack = ~sdaLine;
    tick(H/2);
    mScl = 1'b0; tick(H/2);
  endtask

  task automatic recvByte(output logic [7:0] v, input logic ackIt);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H/2);
      mScl = 1'b1; tick(H/2);
      v[i] = sdaLine;
      tick(H/2);
      mScl = 1'b0;
    end
    tick(H/2);
    mSda = ~ackIt; tick(H/2);
    mScl = 1'b1; tick(H);
    mScl = 1'b0; tick(H/2);
    mSda = 1'b1;
  endtask

  task automatic measureBusy();
    int c = 0;
    for (int i = 0; i < 8 && !busy; i++) tick(1);
    chk(busy, "R5 busy rises after stop", busy, 1);
    while (busy && c < WC + 50) begin c++; tick(1); end
    chk(c == WC, "R5 busy length", c, WC);
    tick(H);
  endtask

  task automatic writeTxn(input int addr, input int n, input int seed, input bit waitDone);
    logic ack;
    logic [10:0] ad = addr[10:0];
    int pa [32];
    int pd [32];
    startBus();
    sendByte({4'b1010, ad[10:8], 1'b0}, ack);
    chk(ack, "R2 device byte ack", ack, 1);
    sendByte(ad[7:0], ack);
    chk(ack, "R3 word address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      pd[k] = (seed + k * 37) & 255;
      pa[k] = (addr & 2032) | ((addr + k) & 15);
      sendByte(pd[k][7:0], ack);
      chk(ack, "R7 data ack (R4 page)", ack, 1);
    end
    stopBus();
    if (waitDone) measureBusy();
    for (int k = 0; k < n; k++)
      if (!(wpLvl && pa[k] >= 1024)) model[pa[k]] = pd[k];
    modelAddr = (addr & 2032) | ((addr + n) & 15);
  endtask

  task automatic readBytes(input int n, input string req);
    logic [7:0] v;
    for (int k = 0; k < n; k++) begin
      recvByte(v, k != n - 1);
      if (model[modelAddr] >= 0)
        chk(int'(v) == model[modelAddr], req, v, model[modelAddr]);
      modelAddr = (modelAddr + 1) & 2047;
    end
    chk(!sda_oe, "R10 line released after NACK", sda_oe, 0);
  endtask

  task automatic randomRead(input int addr, input int n, input string req);
    logic ack;
    logic [10:0] ad = addr[10:0];
    startBus();
    sendByte({4'b1010, ad[10:8], 1'b0}, ack);
    chk(ack, "R9 dummy write device ack", ack, 1);
    sendByte(ad[7:0], ack);
    chk(ack, "R9 word address ack", ack, 1);
    startBus();
    sendByte({4'b1010, 3'b000, 1'b1}, ack);
    chk(ack, "R9 read device ack", ack, 1);
    modelAddr = addr;
    readBytes(n, req);
    stopBus(); tick(H);
  endtask

  task automatic curRead(input int n, input logic [2:0] junkHi);
    logic ack;
    startBus();
    sendByte({4'b1010, junkHi, 1'b1}, ack);
    chk(ack, "R8 current read device ack", ack, 1);
    readBytes(n, "R8 current-address data");
    stopBus(); tick(H);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    bit quiet;
    for (int i = 0; i < 2048; i++) model[i] = -1;
    tick(5);
    chk(!sda_oe && !busy, "R1 reset state", {sda_oe, busy}, 0);
    rst_n = 1'b1;
    tick(10);
    chk(!sda_oe && !busy, "R1 idle after reset", {sda_oe, busy}, 0);

    // R3 single byte, R9 random read
    writeTxn(11'h123, 1, 8'h6C, 1'b1);
    randomRead(11'h123, 1, "R9 random read data");

    // R4 full page then wrapping partial page
    writeTxn(11'h050, 16, 3, 1'b1);
    randomRead(11'h050, 16, "R4 page contents");
    writeTxn(11'h05C, 6, 200, 1'b1);
    randomRead(11'h050, 16, "R4 page wrap contents");
    writeTxn(11'h05C, 6, 90, 1'b1);
    curRead(2, 3'b101);               // R8 counter after write (0x052)
    curRead(1, 3'b000);               // R8 counter after read (0x054)

    // R4 more than 16 bytes: later bytes replace earlier ones
    writeTxn(11'h0A0, 20, 17, 1'b1);
    randomRead(11'h0A0, 16, "R4 overwrite in page");

    // R7 write protect
    writeTxn(11'h500, 1, 8'h11, 1'b1);
    wpLvl = 1'b1;
    writeTxn(11'h500, 1, 8'hEE, 1'b1);
    writeTxn(11'h100, 1, 8'h77, 1'b1);
    wpLvl = 1'b0;
    randomRead(11'h500, 1, "R7 protected byte unchanged");
    randomRead(11'h100, 1, "R7 lower half written");

    // R10 full-counter wrap in sequential read
    writeTxn(11'h7FF, 1, 8'h3C, 1'b1);
    writeTxn(11'h000, 1, 8'hC3, 1'b1);
    randomRead(11'h7FF, 2, "R10 wrap 7FF to 000");

    // R6 polling during write cycle
    writeTxn(11'h200, 2, 8'h40, 1'b0);
    tick(4);
    chk(busy, "R6 busy during poll", busy, 1);
    startBus();
    sendByte({4'b1010, 3'b010, 1'b0}, ack);
    chk(!ack, "R6 no ack while busy", ack, 0);
    stopBus();
    while (busy) tick(1);
    tick(H);
    randomRead(11'h200, 2, "R6 data after poll");

    // R2 wrong device code
    startBus();
    sendByte(8'hE0, ack);
    chk(!ack, "R2 wrong code not acked", ack, 0);
    stopBus(); tick(H);

    // R5 repeated start discards data; stop without data starts no cycle
    startBus();
    sendByte({4'b1010, 3'b000, 1'b0}, ack);
    sendByte(8'h20, ack);
    sendByte(8'h5A, ack);
    startBus();
    stopBus();
    quiet = 1'b1;
    for (int i = 0; i < 20; i++) begin if (busy) quiet = 1'b0; tick(1); end
    chk(quiet, "R5 no cycle after repeated start", !quiet, 0);
    startBus();
    sendByte({4'b1010, 3'b000, 1'b0}, ack);
    sendByte(8'h30, ack);
    stopBus();
    quiet = 1'b1;
    for (int i = 0; i < 20; i++) begin if (busy) quiet = 1'b0; tick(1); end
    chk(quiet, "R5 no cycle without data", !quiet, 0);
    model[11'h020] = model[11'h020];
    randomRead(11'h000, 1, "R5 neighbour unchanged");

    chk(r11Bad == 0, "R11 sda_oe stable while clock high", r11Bad, 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule